// File: doc/BRIEF.md
# Transpose Buffer Sequencer

This block is the controller for a folded row-column two-dimensional transform of size 4, 8, 16 or 32. The arithmetic and the transposition memory live outside it. The block turns a one-cycle start request, which carries a size code, into two back-to-back phases. In the first phase, one row result per cycle is written into the buffer. In the second phase, the buffer is read out one column per cycle for the column pass, and each read is flagged valid.

A single counter times both phases. Its limit is the transform size minus one, and the size is captured when the request is accepted. On the last cycle of a read phase, a new request is taken at once. This lets transforms of any mix of sizes follow one another with no idle gap. A request at any other moment is dropped.

Top module: `xpose_seq_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `wr_en_o`, `out_valid_o`, `wr_addr_o` and `rd_addr_o` all at zero, even if a transform was in progress.
- R2: With no accepted request, the block stays idle. `wr_en_o` and `out_valid_o` stay low, and changes on `len_code_i` alone start nothing.
- R3: A request (`start_i` high) seen in the idle state raises `wr_en_o` in the next cycle and keeps it high for exactly N consecutive cycles, where N is the size.
- R4: The size code maps as 2'b00 to 4, 2'b01 to 8, 2'b10 to 16 and 2'b11 to 32.
- R5: During the write phase, `wr_addr_o` is 0 in its first cycle and increases by one each cycle up to N-1.
- R6: The read phase directly follows the write phase. `out_valid_o` is high for exactly N cycles and `wr_en_o` is low during that time. With no new request, both are low afterwards.
- R7: In the k-th read cycle (k counting from 0), `rd_addr_o` equals k × 32. That is the flat index of column k in a 32×32 buffer, with the column in bits [9:5] and bits [4:0] zero.
- R8: A request on the last read cycle starts a new write phase in the very next cycle, using the size carried by that request.
- R9: A request during the write phase, or on any read cycle other than the last, is ignored and leaves the phase lengths unchanged.
- R10: The size is captured only when a request is accepted. Later changes on `len_code_i` do not alter the transform in progress.
- R11: `wr_en_o` and `out_valid_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Transform request |
| len_code_i | input | 2 | Size code for the request |
| wr_en_o | output | 1 | Buffer write enable for row results |
| wr_addr_o | output | 5 | Row index written in the buffer |
| rd_addr_o | output | 10 | Flat index of the column being read |
| out_valid_o | output | 1 | Column read is valid this cycle |

## Verification
The bench builds the block with its default parameters: a minimum size of 4, a maximum of 32 and a 2-bit code. These defaults reach all four sizes, including the 32-cycle phases that exercise every counter bit and the top column field of the read address. The stimulus table chains transforms from short to long and from long to short. It also injects stray requests and size changes within phases, and directed cases cover reset in the middle of a transform.

// File: rtl/xbuf_pkg.sv
// Package: shared types for the transpose buffer sequencer.
// Assumes: three controller states are enough; encoding is free.
package xbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } xbuf_state_e;

endpackage

// File: rtl/xbuf_len_reg.sv
// Module: xbuf_len_reg
// Captures the size code when a request is accepted and turns it into
// the counter limit (size minus one).
// Assumes: size for code g is MIN_LEN << g, clipped at MAX_LEN.
module xbuf_len_reg #(
    parameter int MIN_LEN = 4,
    parameter int MAX_LEN = 32,
    parameter int CODE_W  = 2,
    parameter int CNT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CNT_W-1:0]  cnt_max
);
    localparam int NUM_CODES = 1 << CODE_W;

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  max_tab [NUM_CODES];

    // Build one limit per code at elaboration.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
        localparam int RAW = MIN_LEN << g;
        localparam int LEN = (RAW > MAX_LEN) ? MAX_LEN : RAW;
        assign max_tab[g] = CNT_W'(LEN - 1);
    end

    // Hold the accepted size code until the next accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= code_in;
        end
    end

    // Look up the limit for the held code.
    assign cnt_max = max_tab[code_q];

    // R10: the captured size only moves on an accepted request.
    a_r10_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code_q));

endmodule

// File: rtl/xbuf_counter.sv
// Module: xbuf_counter
// Phase counter shared by the write and read phases.
// Assumes: clr has priority over inc; the FSM never increments past max.
module xbuf_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] max_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);
    // Clear on phase change, otherwise step when asked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the last cycle of the current phase.
    assign at_max = (cnt == max_val);

    // R5: a step is only ever asked for below the limit.
    a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt < max_val));

    // R5: a plain step raises the count by exactly one.
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/xbuf_fsm.sv
// Module: xbuf_fsm
// Three-state sequencer: idle, row write, column read.
// Assumes: requests are sampled only in idle or on the last read cycle.
module xbuf_fsm
    import xbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        at_max,
    output xbuf_state_e state,
    output logic        cnt_clr,
    output logic        cnt_inc,
    output logic        len_load
);
    xbuf_state_e state_nx;

    // Next state and counter control.
    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        len_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_WRITE;
                    cnt_clr  = 1'b1;
                    len_load = 1'b1;
                end
            end
            ST_WRITE: begin
                if (at_max) begin
                    state_nx = ST_READ;
                    cnt_clr  = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_READ: begin
                if (at_max) begin
                    cnt_clr = 1'b1;
                    if (start) begin
                        state_nx = ST_WRITE;
                        len_load = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_clr  = 1'b1;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // R3: a request in idle opens the write phase.
    a_r3_start_to_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_WRITE));

    // R6: the write phase hands over straight to the read phase.
    a_r6_write_to_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && at_max) |=> (state == ST_READ));

    // R8: a request on the last read cycle chains into a new write.
    a_r8_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && at_max && start) |=> (state == ST_WRITE));

    // R9: a mid-phase request does not disturb the phase.
    a_r9_ignore_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !at_max) |=> (state == $past(state)));

endmodule

// File: rtl/xbuf_addr.sv
// Module: xbuf_addr
// Turns state and count into write/read strobes and addresses.
// Assumes: buffer holds STRIDE x STRIDE elements, column-major reads.
module xbuf_addr
    import xbuf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  xbuf_state_e        state,
    input  logic [CNT_W-1:0]   cnt,
    output logic               wr_en,
    output logic [CNT_W-1:0]   wr_addr,
    output logic [2*CNT_W-1:0] rd_addr,
    output logic               valid
);
    // Decode strobes and gate addresses to zero outside their phase.
    always_comb begin
        wr_en   = (state == ST_WRITE);
        valid   = (state == ST_READ);
        wr_addr = wr_en ? cnt : '0;
        rd_addr = valid ? {cnt, {CNT_W{1'b0}}} : '0;
    end

    // R11: write and read strobes are exclusive.
    always_comb begin
        a_r11_exclusive: assert (!(wr_en && valid));
    end

endmodule

// File: rtl/xpose_seq_ctrl.sv
// Module: xpose_seq_ctrl (top)
// Controller for a folded row-column transform: write N row results,
// then read N columns, N taken from the size code on the request.
// Assumes: MAX_LEN is a power of two; buffer arithmetic lives elsewhere.
module xpose_seq_ctrl
    import xbuf_pkg::*;
#(
    parameter int MIN_LEN = 4,
    parameter int MAX_LEN = 32,
    parameter int CODE_W  = 2,
    localparam int CNT_W  = $clog2(MAX_LEN),
    localparam int RA_W   = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] len_code_i,
    output logic              wr_en_o,
    output logic [CNT_W-1:0]  wr_addr_o,
    output logic [RA_W-1:0]   rd_addr_o,
    output logic              out_valid_o
);
    xbuf_state_e      state;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             len_load;
    logic             at_max;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_max;

    xbuf_len_reg #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .CODE_W  (CODE_W),
        .CNT_W   (CNT_W)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (len_load),
        .code_in (len_code_i),
        .cnt_max (cnt_max)
    );

    xbuf_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .max_val (cnt_max),
        .cnt     (cnt),
        .at_max  (at_max)
    );

    xbuf_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .at_max   (at_max),
        .state    (state),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .len_load (len_load)
    );

    xbuf_addr #(
        .CNT_W (CNT_W)
    ) u_addr (
        .state   (state),
        .cnt     (cnt),
        .wr_en   (wr_en_o),
        .wr_addr (wr_addr_o),
        .rd_addr (rd_addr_o),
        .valid   (out_valid_o)
    );

    // R1: reset forces both strobes low in the next cycle.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!wr_en_o && !out_valid_o));

    // R2: from idle, nothing starts without a request.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_o && !out_valid_o && !start_i) |=> (!wr_en_o && !out_valid_o));

    // R6: the read phase never precedes a write phase directly from idle.
    a_r6_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> $past(wr_en_o));

endmodule

// File: tb/sim_xpose_seq_ctrl.sv
`timescale 1ns/100ps
module sim_xpose_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [1:0] len_code_i;
    logic       wr_en_o;
    logic [4:0] wr_addr_o;
    logic [9:0] rd_addr_o;
    logic       out_valid_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    xpose_seq_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_code_i  (len_code_i),
        .wr_en_o     (wr_en_o),
        .wr_addr_o   (wr_addr_o),
        .rd_addr_o   (rd_addr_o),
        .out_valid_o (out_valid_o)
    );

    // Vector table: size code, expected size, stray requests, chain next.
    localparam int NV = 6;
    localparam int T_CODE  [NV] = '{0, 1, 2, 3, 0, 1};
    localparam int T_LEN   [NV] = '{4, 8, 16, 32, 4, 8};
    localparam int T_STRAY [NV] = '{0, 1, 0, 1, 1, 0};
    localparam int T_CHAIN [NV] = '{0, 0, 1, 1, 1, 0};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Walk the vector table, then directed cases.
    initial begin
        bit in_write;
        rst_n = 1'b0;
        start_i = 1'b0;
        len_code_i = 2'd0;
        repeat (3) @(negedge clk);
        check("R1 wr_en", int'(wr_en_o), 0);
        check("R1 valid", int'(out_valid_o), 0);
        check("R1 wr_addr", int'(wr_addr_o), 0);
        check("R1 rd_addr", int'(rd_addr_o), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            len_code_i = 2'(i);
            @(negedge clk);
            check("R2 idle wr_en", int'(wr_en_o), 0);
            check("R2 idle valid", int'(out_valid_o), 0);
        end

        in_write = 1'b0;
        for (int k = 0; k < NV; k++) begin
            int n;
            bit chained;
            n = T_LEN[k];
            chained = in_write;
            if (!in_write) begin
                start_i = 1'b1;
                len_code_i = 2'(T_CODE[k]);
                @(negedge clk);
            end
            start_i = 1'b0;
            for (int i = 0; i < n; i++) begin
                check((i == 0 && chained) ? "R8 chained write" : "R3 wr_en",
                      int'(wr_en_o), 1);
                check("R5 wr_addr", int'(wr_addr_o), i);
                check("R11 valid in write", int'(out_valid_o), 0);
                if (T_STRAY[k] != 0 && i == 1) begin
                    start_i = 1'b1;
                    len_code_i = ~2'(T_CODE[k]);
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
            for (int i = 0; i < n; i++) begin
                check((T_STRAY[k] != 0) ? "R9 R10 valid" : "R4 R6 valid",
                      int'(out_valid_o), 1);
                check("R6 wr_en in read", int'(wr_en_o), 0);
                check("R7 rd_addr", int'(rd_addr_o), i * 32);
                if (i == n - 1 && T_CHAIN[k] != 0) begin
                    start_i = 1'b1;
                    len_code_i = 2'(T_CODE[k + 1]);
                end else if (T_STRAY[k] != 0 && i == 2) begin
                    start_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
            start_i = 1'b0;
            if (T_CHAIN[k] != 0) begin
                in_write = 1'b1;
            end else begin
                in_write = 1'b0;
                check("R6 end wr_en", int'(wr_en_o), 0);
                check("R6 end valid", int'(out_valid_o), 0);
            end
        end

        // Directed: reset in the middle of a 32-size transform.
        start_i = 1'b1;
        len_code_i = 2'd3;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R3 before reset", int'(wr_en_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid wr_en", int'(wr_en_o), 0);
        check("R1 mid wr_addr", int'(wr_addr_o), 0);
        check("R1 mid valid", int'(out_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 post reset idle", int'(wr_en_o), 0);

        // Directed: size-4 transform after reset reads for 4 cycles only.
        start_i = 1'b1;
        len_code_i = 2'd0;
        @(negedge clk);
        start_i = 1'b0;
        len_code_i = 2'd3;
        repeat (4) @(negedge clk);
        check("R4 size4 read start", int'(out_valid_o), 1);
        repeat (3) @(negedge clk);
        check("R7 last col", int'(rd_addr_o), 96);
        @(negedge clk);
        check("R10 size4 ends", int'(out_valid_o), 0);
        check("R2 back idle", int'(wr_en_o), 0);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule